// File: doc/BRIEF.md
# Drive Ready-Line Scanner

This block watches the ready lines of a set of disk drives while the controller has nothing else to do. It steps a drive-select code through every drive in turn. At each drive it waits a programmable number of clocks, then takes a sample of the shared ready input, which has passed through a synchroniser. It keeps the last sampled ready level for each drive. When a drive's level differs from the one stored for it, the block marks that drive as changed and raises an interrupt request.

The command sequencer enables scanning once the controller has been configured. It also marks the windows when scanning may run: between commands, and between the step pulses of a seek. When software issues a sense-interrupt-status request, the block returns a status byte for one changed drive. Changed drives are reported one per request, lowest drive number first. The interrupt stays up until every changed drive has been reported.

Top module: `drive_ready_poller`

## Requirements
- R1: After reset, `drv_sel` is 0, `irq` is 0 and `st0` is 0x00.
- R2: While `cfg_done` is low, `drv_sel` holds its value and a change on the ready input raises no interrupt.
- R3: Scanning runs only while both `cfg_done` and `idle` are high. While `idle` is low, `drv_sel` holds. A ready change that is undone before `idle` returns high raises no interrupt.
- R4: While scanning, `drv_sel` advances by one, wrapping from 3 to 0, every max(`dwell_len`, 3) clocks. A `dwell_len` of 0, 1 or 2 gives a period of 3.
- R5: The first sample of each drive after `cfg_done` rises only sets that drive's stored level and raises no interrupt. This holds even if the level differs from the one stored before `cfg_done` fell.
- R6: A sampled level that differs from the stored level of that drive marks the drive as changed. This applies to a ready-to-not-ready change and to a not-ready-to-ready change alike. `irq` is high exactly while at least one drive is marked.
- R7: A `sense_req` with drives marked loads `st0` on the next clock with the status of the lowest-numbered marked drive, and clears that drive's mark. The byte has bits 7:6 = 11, bit 3 = 1 when that drive's stored level is not ready, bits 1:0 = the drive number, and all other bits 0.
- R8: A `sense_req` with no drive marked loads `st0` with 0x80 and changes no mark.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_done | input | 1 | Configuration received; enables scanning |
| idle | input | 1 | Controller is between commands or between step pulses |
| dwell_len | input | DWELL_W | Clocks spent on each drive (minimum 3 applied) |
| rdy_in | input | 1 | Ready line of the currently selected drive, asynchronous |
| sense_req | input | 1 | One-clock sense-interrupt-status request |
| drv_sel | output | $clog2(NUM_DRIVES) | Drive-select code |
| irq | output | 1 | Interrupt request: a ready change is waiting to be reported |
| st0 | output | 8 | Status byte from the last sense request |

## Verification
A wrong stored level or a lost baseline flag shows at the ports as a spurious or missing interrupt. It appears within one full scan, which is four dwell periods. A mark that never clears leaves `irq` stuck after the last sense. A wrong priority pick shows up as a byte out of order on the very next sense. A select counter that is off by one, or a dwell clamp that is wrong, changes the spacing of the `drv_sel` steps from the first step after enable. That spacing is measured edge to edge.

// File: rtl/drp_pkg.sv
package drp_pkg;
   localparam logic [7:0] ST0_NONE = 8'h80;
   localparam logic [1:0] ST0_RDY_CHG = 2'b11;

   function automatic logic [7:0] st0_encode(input logic [1:0] drv, input logic not_rdy);
      logic [7:0] b;
      b = '0;
      b[7:6] = ST0_RDY_CHG;
      b[3] = not_rdy;
      b[1:0] = drv;
      return b;
   endfunction
endpackage

// File: rtl/drp_sync.sv
module drp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("drp_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/drp_scan.sv
module drp_scan #(
   parameter int NUM_DRIVES = 4,
   parameter int DWELL_W    = 8,
   parameter int MIN_DWELL  = 3,
   localparam int SEL_W     = $clog2(NUM_DRIVES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [DWELL_W-1:0] dwell_len,
   output logic [SEL_W-1:0]   sel,
   output logic               sample
);
   localparam logic [DWELL_W-1:0] MIN_D = DWELL_W'(MIN_DWELL);

   logic [DWELL_W-1:0] cnt;
   logic [DWELL_W-1:0] eff;
   logic               last;

   generate
      if (MIN_DWELL >= (1 << DWELL_W)) begin : g_bad
         $error("DWELL_W too narrow for minimum dwell");
      end
   endgenerate

   assign eff    = (dwell_len < MIN_D) ? MIN_D : dwell_len;
   assign last   = (cnt == eff - 1'b1);
   assign sample = run && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sel <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (last) begin
         cnt <= '0;
         sel <= sel + 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/drp_track.sv
module drp_track
   import drp_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   localparam int SEL_W     = $clog2(NUM_DRIVES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_done,
   input  logic             sample,
   input  logic [SEL_W-1:0] sel,
   input  logic             rdy_s,
   input  logic             sense_req,
   output logic             irq,
   output logic [7:0]       st0
);
   logic [NUM_DRIVES-1:0] lvl, based, pend, set_v, clr_v;
   logic [SEL_W-1:0]      pick;
   logic                  any;

   generate
      for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
         logic hit;
         assign hit      = sample && (sel == SEL_W'(i));
         assign set_v[i] = hit && based[i] && (rdy_s != lvl[i]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl[i]   <= 1'b0;
               based[i] <= 1'b0;
            end else if (!cfg_done) begin
               based[i] <= 1'b0;
            end else if (hit) begin
               lvl[i]   <= rdy_s;
               based[i] <= 1'b1;
            end
         end
      end
   endgenerate

   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int k = NUM_DRIVES - 1; k >= 0; k--) begin
         if (pend[k]) begin
            pick = SEL_W'(k);
            any  = 1'b1;
         end
      end
   end

   always_comb begin
      clr_v = '0;
      if (sense_req && any) clr_v[pick] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= '0;
         st0  <= '0;
      end else begin
         pend <= (pend & ~clr_v) | set_v;
         if (sense_req) st0 <= any ? st0_encode(2'(pick), ~lvl[pick]) : ST0_NONE;
      end
   end

   assign irq = |pend;
endmodule

// File: rtl/drive_ready_poller.sv
module drive_ready_poller #(
   parameter int NUM_DRIVES  = 4,
   parameter int DWELL_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_done,
   input  logic                          idle,
   input  logic [DWELL_W-1:0]            dwell_len,
   input  logic                          rdy_in,
   input  logic                          sense_req,
   output logic [$clog2(NUM_DRIVES)-1:0] drv_sel,
   output logic                          irq,
   output logic [7:0]                    st0
);
   localparam int SEL_W     = $clog2(NUM_DRIVES);
   localparam int MIN_DWELL = SYNC_STAGES + 1;

   logic rdy_s, sample, run;

   generate
      if (NUM_DRIVES < 2 || NUM_DRIVES > 4 || (1 << SEL_W) != NUM_DRIVES) begin : g_bad
         $error("NUM_DRIVES must be 2 or 4 to fit the status drive field");
      end
   endgenerate

   assign run = cfg_done && idle;

   drp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_s)
   );

   drp_scan #(.NUM_DRIVES(NUM_DRIVES), .DWELL_W(DWELL_W), .MIN_DWELL(MIN_DWELL)) u_scan (
      .clk(clk), .rst_n(rst_n), .run(run), .dwell_len(dwell_len),
      .sel(drv_sel), .sample(sample)
   );

   drp_track #(.NUM_DRIVES(NUM_DRIVES)) u_track (
      .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .sample(sample), .sel(drv_sel),
      .rdy_s(rdy_s), .sense_req(sense_req), .irq(irq), .st0(st0)
   );
endmodule

// File: rtl/drp_chk.sv
module drp_chk #(
   parameter int SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_done,
   input logic             idle,
   input logic             sense_req,
   input logic [SEL_W-1:0] drv_sel,
   input logic             irq,
   input logic [7:0]       st0
);
   // R2
   sel_hold_unconfigured_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |=> $stable(drv_sel));

   // R3
   sel_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(drv_sel));

   // R4
   sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_sel != $past(drv_sel)) |-> (drv_sel == SEL_W'($past(drv_sel) + 1'b1)));

   // R6
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(sense_req));

   // R7
   st0_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st0[5:4] == 2'b00) && (st0[2] == 1'b0));

   // R8
   empty_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_req && !irq) |=> (st0 == 8'h80));
endmodule

bind drive_ready_poller drp_chk #(.SEL_W($clog2(NUM_DRIVES))) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .idle(idle), .sense_req(sense_req),
   .drv_sel(drv_sel), .irq(irq), .st0(st0)
);

// File: tb/drive_ready_poller_tb.sv
module drive_ready_poller_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_done = 1'b0;
   logic       idle = 1'b1;
   logic [7:0] dwell_len = 8'd4;
   logic       sense_req = 1'b0;
   logic [3:0] drv_rdy = 4'b1111;
   logic       rdy_in;
   logic [1:0] drv_sel;
   logic       irq;
   logic [7:0] st0;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign rdy_in = drv_rdy[drv_sel];

   drive_ready_poller u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .idle(idle), .dwell_len(dwell_len),
      .rdy_in(rdy_in), .sense_req(sense_req), .drv_sel(drv_sel), .irq(irq), .st0(st0)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sense(input logic [7:0] expected);
      exp_q.push_back(expected);
      @(negedge clk) sense_req = 1'b1;
      @(negedge clk) sense_req = 1'b0;
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      while (!irq && n < 200) begin
         @(negedge clk);
         n++;
      end
      check(req, irq, 1'b1);
   endtask

   task automatic measure_period(input string req, input int exp_len);
      logic [1:0] s0;
      int n;
      s0 = drv_sel;
      n = 0;
      while (drv_sel == s0 && n < 100) begin @(negedge clk); n++; end
      for (int t = 0; t < 4; t++) begin
         s0 = drv_sel;
         n = 0;
         while (drv_sel == s0 && n < 100) begin @(negedge clk); n++; end
         check(req, n, exp_len);
         check(req, drv_sel, 2'(s0 + 2'd1));
      end
   endtask

   // scoreboard monitor: one expected byte per sense request
   initial begin
      forever begin
         @(posedge clk);
         if (sense_req) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R7: unexpected sense result %0h, expected none", st0);
            end else begin
               check("R7/R8 st0", st0, exp_q.pop_front());
            end
         end
      end
   end

   initial begin
      wait_cyc(20000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [1:0] s;
      wait_cyc(3);
      // R1 reset state
      check("R1 sel", drv_sel, 2'd0);
      check("R1 irq", irq, 1'b0);
      check("R1 st0", st0, 8'h00);
      rst_n = 1'b1;

      // R2 no scanning before configuration
      wait_cyc(10);
      drv_rdy[0] = 1'b0;
      wait_cyc(40);
      check("R2 sel", drv_sel, 2'd0);
      check("R2 irq", irq, 1'b0);
      drv_rdy[0] = 1'b1;

      // R4 period with dwell 4, R5 baseline scan
      cfg_done = 1'b1;
      measure_period("R4 dwell4", 4);
      wait_cyc(40);
      check("R5 baseline no irq", irq, 1'b0);

      // R6 falling then rising on drive 2
      drv_rdy[2] = 1'b0;
      wait_irq("R6 fall irq");
      sense(8'hCA);
      wait_cyc(1);
      check("R6 irq cleared", irq, 1'b0);
      drv_rdy[2] = 1'b1;
      wait_irq("R6 rise irq");
      sense(8'hC2);
      wait_cyc(1);
      check("R6 irq cleared 2", irq, 1'b0);

      // R7 two drives pending, ascending order
      drv_rdy[3] = 1'b0;
      drv_rdy[0] = 1'b0;
      wait_cyc(40);
      check("R7 irq pending", irq, 1'b1);
      sense(8'hC8);
      wait_cyc(1);
      check("R7 irq held", irq, 1'b1);
      sense(8'hCB);
      wait_cyc(1);
      check("R7 irq cleared", irq, 1'b0);

      // R8 empty sense
      sense(8'h80);
      wait_cyc(1);
      check("R8 irq", irq, 1'b0);

      // R3 busy window: select holds, transient change unseen
      idle = 1'b0;
      wait_cyc(2);
      s = drv_sel;
      drv_rdy[1] = 1'b0;
      wait_cyc(50);
      check("R3 sel hold", drv_sel, s);
      check("R3 irq", irq, 1'b0);
      drv_rdy[1] = 1'b1;
      idle = 1'b1;
      wait_cyc(40);
      check("R3 no irq after resume", irq, 1'b0);

      // R4 clamp to minimum dwell
      dwell_len = 8'd0;
      measure_period("R4 dwell0", 3);
      dwell_len = 8'd2;
      measure_period("R4 dwell2", 3);
      dwell_len = 8'd4;

      // R5 re-baseline after cfg_done drops
      cfg_done = 1'b0;
      drv_rdy[1] = 1'b0;
      wait_cyc(10);
      cfg_done = 1'b1;
      wait_cyc(40);
      check("R5 rebaseline no irq", irq, 1'b0);
      sense(8'h80);
      wait_cyc(2);
      check("R5 queue drained", exp_q.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule